// File: doc/BRIEF.md
# Four-Phase Processor Cycle Sequencer

This block divides each processor cycle into four consecutive stages, T1 to T4, and it runs from a free-running master clock. Each stage lasts one master-clock period. For each stage there is one active-low phase output, and that output is low only during its own stage. Because of this, the phases never overlap, and in free running each phase is high for three periods out of four. Two more active-low outputs mark the halves of the cycle. The early group covers T1 and T2. The late group covers T3 and T4, which is when the processor owns the bus, so another master may use the bus during the early half without waiting.

A slow memory or peripheral can stretch T3 by pulling the wait request low. The request passes through a two-flop synchroniser, and the sequencer acts on it only while it is in T3.

For debugging, a stepping mode stops the sequencer after T4 with every output high. In that mode, each rising edge of the step input runs exactly one full T1 to T4 cycle. A step edge that arrives during a cycle is remembered, and it starts the next cycle. All outputs come straight from flip-flops.

Top module: `quad_phase_clkgen`

## Requirements
- R1: While `rst` is high at a clock edge, all six outputs are high after that edge. In free-running mode, the first period after `rst` falls is T1.
- R2: With no wait request, the stages follow the order T1, T2, T3, T4, and each lasts one period. After T4 the sequence returns to T1 while `step_mode` is 0.
- R3: At most one bit of `ph_n` is low in any period. `ph_n[i]` low means stage T(i+1), so bit 0 is T1 and bit 3 is T4. In free running each bit is low for one period in four.
- R4: `grp_early_n` is low exactly when `ph_n[0]` or `ph_n[1]` is low. `grp_late_n` is low exactly when `ph_n[2]` or `ph_n[3]` is low. Both are high when the sequencer is idle.
- R5: `wait_n` (low means wait) passes through two flops. While the synchronised request is low in T3, the sequencer stays in T3. If `wait_n` is low at k consecutive edges, starting at the T1-to-T2 edge, T3 lasts k+1 periods and is then followed by T4.
- R6: A `wait_n` low that is seen only at the T3-to-T4 edge, or only at the T4-to-T1 edge, leaves every stage of the following cycles at one period.
- R7: When `step_mode` is 1 at the edge that leaves T4, the sequencer goes idle with all outputs high. It stays idle until a step is taken.
- R8: In stepping mode, a rise of `step_req` (0 at one edge, 1 at the next) starts one T1 to T4 cycle at the edge where the 1 is first seen. Holding `step_req` high starts no further cycle.
- R9: A `step_req` rise seen during a stepping cycle is stored. After that cycle's T4, the sequencer spends one idle period and then runs one more cycle.
- R10: When `step_mode` returns to 0 while the sequencer is idle, T1 starts in the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wait_n | input | 1 | Wait-state request from memory or peripheral, active low, asynchronous |
| step_mode | input | 1 | 1 selects single-cycle stepping |
| step_req | input | 1 | Step control; each rising edge runs one cycle in stepping mode |
| ph_n | output | 4 | Phase outputs, active low; bit i marks stage T(i+1) |
| grp_early_n | output | 1 | Low during T1 and T2 |
| grp_late_n | output | 1 | Low during T3 and T4 (processor owns the bus) |

## Verification
The free-running pattern comes straight out of reset and checks the stage order, the wrap and the one-in-four duty. A wait request held for three edges from the T1-to-T2 edge tests the exact stretch length of T3, which depends on the synchroniser latency. Single-period wait pulses placed at the T3-to-T4 and T4-to-T1 edges show that requests outside T3 are ignored, as opposed to being acted on late. In stepping mode, a short step pulse, a held step level and a step edge arriving mid-cycle tell apart edge detection, level sensitivity and the stored pending step. A reset applied mid-cycle and the return to free running are also tested.

// File: rtl/qps_pkg.sv
package qps_pkg;
  localparam int PHASES   = 4;
  localparam int IDX_W    = $clog2(PHASES);
  localparam int HALF     = PHASES / 2;
  localparam int WAIT_IDX = 2;

  typedef struct packed {
    logic             run;
    logic [IDX_W-1:0] idx;
  } seq_state_t;

  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(PHASES - 1);
  localparam logic [IDX_W-1:0] HOLD_IDX  = IDX_W'(WAIT_IDX);
  localparam seq_state_t       IDLE_STATE = '{run: 1'b0, idx: '0};
  localparam seq_state_t       FIRST_STATE = '{run: 1'b1, idx: '0};
endpackage

// File: rtl/qps_wait_sync.sv
module qps_wait_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n,
  output logic hold
);
  logic [SYNC_STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[SYNC_STAGES-2:0], req_n};
  end

  assign hold = ~chain[SYNC_STAGES-1];
endmodule

// File: rtl/qps_step_ctrl.sv
module qps_step_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic step_mode,
  input  logic step_req,
  input  logic idle,
  output logic go
);
  logic step_q;
  logic pend;
  logic rise;
  logic start;

  assign rise  = step_req & ~step_q;
  assign go    = ~step_mode | rise | pend;
  assign start = idle & go;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      step_q <= step_req;
      pend   <= step_mode & ~start & (pend | rise);
    end
  end
endmodule

// File: rtl/qps_stage_seq.sv
module qps_stage_seq
  import qps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic       step_mode,
  input  logic       go,
  output logic       idle,
  output seq_state_t nxt
);
  seq_state_t cur;

  always_comb begin
    nxt = cur;
    if (!cur.run) begin
      if (go) nxt = FIRST_STATE;
    end else if (cur.idx == HOLD_IDX && hold) begin
      nxt = cur;
    end else if (cur.idx == LAST_IDX) begin
      nxt = step_mode ? IDLE_STATE : FIRST_STATE;
    end else begin
      nxt.idx = cur.idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= IDLE_STATE;
    else     cur <= nxt;
  end

  assign idle = ~cur.run;
endmodule

// File: rtl/qps_out_reg.sv
module qps_out_reg
  import qps_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  seq_state_t        nxt,
  output logic [PHASES-1:0] ph_n,
  output logic              grp_early_n,
  output logic              grp_late_n
);
  genvar gi;
  generate
    for (gi = 0; gi < PHASES; gi++) begin : g_phase
      always_ff @(posedge clk) begin
        if (rst) ph_n[gi] <= 1'b1;
        else     ph_n[gi] <= ~(nxt.run && nxt.idx == IDX_W'(gi));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_early_n <= 1'b1;
      grp_late_n  <= 1'b1;
    end else begin
      grp_early_n <= ~(nxt.run && nxt.idx <  IDX_W'(HALF));
      grp_late_n  <= ~(nxt.run && nxt.idx >= IDX_W'(HALF));
    end
  end
endmodule

// File: rtl/quad_phase_clkgen.sv
module quad_phase_clkgen
  import qps_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wait_n,
  input  logic              step_mode,
  input  logic              step_req,
  output logic [PHASES-1:0] ph_n,
  output logic              grp_early_n,
  output logic              grp_late_n
);
  logic       wait_act;
  logic       go;
  logic       idle;
  seq_state_t nxt;

  qps_wait_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .req_n(wait_n), .hold(wait_act)
  );

  qps_step_ctrl u_step (
    .clk(clk), .rst(rst), .step_mode(step_mode), .step_req(step_req),
    .idle(idle), .go(go)
  );

  qps_stage_seq u_seq (
    .clk(clk), .rst(rst), .hold(wait_act), .step_mode(step_mode),
    .go(go), .idle(idle), .nxt(nxt)
  );

  qps_out_reg u_out (
    .clk(clk), .rst(rst), .nxt(nxt), .ph_n(ph_n),
    .grp_early_n(grp_early_n), .grp_late_n(grp_late_n)
  );
endmodule

// File: rtl/qps_checker.sv
module qps_checker
  import qps_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [PHASES-1:0] ph_n,
  input logic              grp_early_n,
  input logic              grp_late_n,
  input logic              hold_sync,
  input logic              step_mode
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (&ph_n && grp_early_n && grp_late_n)); // R1

  AST_T1_TO_T2: assert property (@(posedge clk) disable iff (rst)
    !ph_n[0] |=> !ph_n[1]); // R2

  AST_T2_TO_T3: assert property (@(posedge clk) disable iff (rst)
    !ph_n[1] |=> !ph_n[2]); // R2

  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!ph_n[3] && !step_mode) |=> !ph_n[0]); // R2

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $countones(~ph_n) <= 1); // R3

  AST_GROUPS: assert property (@(posedge clk) disable iff (rst)
    (grp_early_n == (ph_n[0] & ph_n[1])) &&
    (grp_late_n  == (ph_n[2] & ph_n[3]))); // R4

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ph_n[2] && hold_sync) |=> !ph_n[2]); // R5

  AST_WAIT_LEAVE: assert property (@(posedge clk) disable iff (rst)
    (!ph_n[2] && !hold_sync) |=> !ph_n[3]); // R5

  AST_STEP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!ph_n[3] && step_mode) |=> &ph_n); // R7
endmodule

bind quad_phase_clkgen qps_checker u_chk (
  .clk(clk), .rst(rst), .ph_n(ph_n), .grp_early_n(grp_early_n),
  .grp_late_n(grp_late_n), .hold_sync(wait_act), .step_mode(step_mode)
);

// File: tb/tb_quad_phase_clkgen.sv
module tb_quad_phase_clkgen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       wait_n;
  logic       step_mode;
  logic       step_req;
  logic [3:0] ph_n;
  logic       grp_early_n;
  logic       grp_late_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_phase_clkgen dut (
    .clk(clk), .rst(rst), .wait_n(wait_n), .step_mode(step_mode),
    .step_req(step_req), .ph_n(ph_n), .grp_early_n(grp_early_n),
    .grp_late_n(grp_late_n)
  );

  // exp: 0 = idle, 1..4 = stage T1..T4
  task automatic chk(input int exp, input string tag);
    logic [5:0] want;
    logic [5:0] got;
    @(negedge clk);
    want[5:2] = (exp == 0) ? 4'hF : ~(4'b0001 << (exp - 1));
    want[1]   = !(exp == 1 || exp == 2);
    want[0]   = !(exp == 3 || exp == 4);
    got = {ph_n, grp_early_n, grp_late_n};
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: outputs {ph_n,early,late}=%b expected %b (stage %0d)",
               tag, got, want, exp);
    end
  endtask

  task automatic t_reset_and_run();
    rst = 1'b1; wait_n = 1'b1; step_mode = 1'b0; step_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(0, "R1 reset");
    rst = 1'b0;
    for (int i = 0; i < 8; i++) chk((i % 4) + 1, "R2 R3 R4 free run");
  endtask

  task automatic t_wait_hold();
    chk(1, "R5 T1");
    wait_n = 1'b0;
    chk(2, "R5 T2");
    chk(3, "R5 T3 first");
    chk(3, "R5 T3 held");
    wait_n = 1'b1;
    chk(3, "R5 T3 held");
    chk(3, "R5 T3 last");
    chk(4, "R5 T4 after wait");
    chk(1, "R5 T1 after wait");
    chk(2, "R5 T2 after wait");
  endtask

  task automatic t_wait_ignored();
    chk(3, "R6 T3");
    wait_n = 1'b0;
    chk(4, "R6 T4");
    wait_n = 1'b1;
    chk(1, "R6 T1");
    chk(2, "R6 T2");
    chk(3, "R6 T3 single");
    chk(4, "R6 T4");
    wait_n = 1'b0;
    chk(1, "R6 T1");
    wait_n = 1'b1;
    chk(2, "R6 T2");
    chk(3, "R6 T3 single");
    chk(4, "R6 T4");
  endtask

  task automatic t_step();
    chk(1, "R7 T1");
    step_mode = 1'b1;
    chk(2, "R7 T2");
    chk(3, "R7 T3");
    chk(4, "R7 T4");
    for (int i = 0; i < 3; i++) chk(0, "R7 idle");
    step_req = 1'b1;
    chk(1, "R8 T1 on step");
    chk(2, "R8 T2");
    chk(3, "R8 T3");
    chk(4, "R8 T4");
    chk(0, "R8 idle with step held");
    chk(0, "R8 idle with step held");
    step_req = 1'b0;
    chk(0, "R8 idle");
    step_req = 1'b1;
    chk(1, "R9 T1");
    step_req = 1'b0;
    chk(2, "R9 T2");
    step_req = 1'b1;
    chk(3, "R9 T3");
    step_req = 1'b0;
    chk(4, "R9 T4");
    chk(0, "R9 one idle");
    chk(1, "R9 pending T1");
    chk(2, "R9 T2");
    chk(3, "R9 T3");
    chk(4, "R9 T4");
    chk(0, "R9 idle");
    chk(0, "R9 idle");
    step_mode = 1'b0;
    chk(1, "R10 free T1");
    chk(2, "R10 free T2");
  endtask

  task automatic t_mid_reset();
    rst = 1'b1;
    chk(0, "R1 mid reset");
    chk(0, "R1 mid reset");
    rst = 1'b0;
    chk(1, "R1 T1 after reset");
    chk(2, "R1 T2 after reset");
  endtask

  initial begin
    t_reset_and_run();
    t_wait_hold();
    t_wait_ignored();
    t_step();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule